// File: doc/BRIEF.md
# Conditional-Write Interrupt Status Register

This block holds an 8-bit interrupt condition register and a companion snapshot register, both reached over a byte-wide control bus with an address, a read strobe, a write strobe and separate write and read data. Event inputs from the rest of the chip set condition bits. Once set, a bit stays set. The block raises an interrupt while any condition bit is 1. A host handles the interrupt in two steps. It reads the condition register, and it then writes back the value it read to clear what it has handled.

Each host read of the condition register copies that register's value into the snapshot register. When the host writes the condition register, the write is applied one bit at a time. A bit that still equals its snapshot takes the written value. A bit that has changed since the last read keeps its current value. If any bit is held back in this way, the block sets the write-inhibit flag in the condition register. This lets the host see that part of its write was refused. The host cannot clear an event that it has never read. The host can also read and write the snapshot register directly.

Bus map: the condition register is at address 0x19 and the snapshot register is at address 0x1A. Any other address reads as 0x00. Read data is combinational, and it is valid in the cycle in which the read strobe is high. Writes and captures take effect at the rising clock edge. Reset is synchronous and active high.

Top module: `icr_condwrite`

## Requirements
- R1: After reset, the condition register and the snapshot register are both 0x00, and irq is 0.
- R2: While bus_rd is high, bus_rdata shows the condition register at address 0x19 and the snapshot register at address 0x1A. Any other address reads 0x00.
- R3: At the end of every read cycle of the condition register (0x19), the value read is copied into the snapshot register.
- R4: In a write to 0x19, each bit that equals its snapshot bit takes the written value, whether that value is 0 or 1.
- R5: In a write to 0x19, a bit that differs from its snapshot bit keeps its current value.
- R6: If any bit differs from its snapshot bit during a write to 0x19, bit 3 (the write-inhibit flag) is 1 after that write.
- R7: If an event input is 1 in the same cycle as a write to 0x19, the matching condition bit is 1 after that cycle, even when the write would clear it.
- R8: A 1 on event_in[i] sets condition bit i. The bit then stays set until a write that is allowed to clear it. Bit i has this meaning: 0 request-data parity, 1 bus parity, 2 write-command reject, 3 write inhibit, 4 link-error threshold, 5 receive A, 6 receive B, 7 user.
- R9: irq is 1 exactly when at least one condition bit is 1.
- R10: A write to 0x1A loads the written byte into the snapshot register and leaves the condition register unchanged.
- R11: Bit 3 follows the same snapshot rule as every other bit. It clears when it matches its snapshot bit and is written 0. It is held, and then forced to 1, when it differs from its snapshot bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| event_in | input | 8 | Per-bit condition set requests |
| irq | output | 1 | Interrupt, the OR of all condition bits |

## Verification
The bench covers these corner cases:

- A write-back made without a fresh read. A design that ignores the snapshot would clear an event that the host never saw, and the inhibit flag would stay 0.
- An event that arrives in the same cycle as a clearing write. A design that gives the write priority would lose that event.
- Loading the snapshot register directly. A wrong decode would corrupt the condition register, or would fail to make the next write-back be refused.
- The inhibit flag as a protected bit. It must clear when it matches its snapshot bit, and it must be forced back to 1 when it does not. A design that exempts this bit would get one of those two cases wrong.

// File: rtl/icr_pkg.sv
package icr_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] COND_ADDR = 8'h19;
    localparam logic [ADDR_W-1:0] COMP_ADDR = 8'h1A;

    typedef logic [DATA_W-1:0] cond_t;

    // Bit positions inside the condition register
    typedef enum int unsigned {
        BIT_REQ_PAR    = 0,
        BIT_BUS_PAR    = 1,
        BIT_WR_REJECT  = 2,
        BIT_WR_INHIBIT = 3,
        BIT_LINK_THR   = 4,
        BIT_RX_A       = 5,
        BIT_RX_B       = 6,
        BIT_USER       = 7
    } cond_bit_e;

    localparam int unsigned INHIBIT_POS = int'(BIT_WR_INHIBIT);
    localparam cond_t INHIBIT_MASK = cond_t'(1) << INHIBIT_POS;

    // Decoded bus access, one strobe per register and direction
    typedef struct packed {
        logic rd_cond;
        logic rd_comp;
        logic wr_cond;
        logic wr_comp;
    } bus_acc_t;

    // Bits that changed since the host last captured a snapshot
    function automatic cond_t stale_bits(cond_t cur, cond_t snap);
        return cur ^ snap;
    endfunction

    // Next value of one condition bit
    function automatic logic bit_next(logic cur, logic stale, logic wr,
                                      logic wd, logic force_one, logic ev);
        logic v;
        v = cur;
        if (wr && !stale) v = wd;
        if (force_one)    v = 1'b1;
        return v | ev;
    endfunction

endpackage

// File: rtl/icr_bus_decode.sv
module icr_bus_decode
    import icr_pkg::*;
#(
    parameter int unsigned            AW   = ADDR_W,
    parameter logic [ADDR_W-1:0]      A_CND = COND_ADDR,
    parameter logic [ADDR_W-1:0]      A_CMP = COMP_ADDR
) (
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    output bus_acc_t      acc
);

    logic hit_cond;
    logic hit_comp;

    always_comb begin
        hit_cond    = (addr == AW'(A_CND));
        hit_comp    = (addr == AW'(A_CMP));
        acc.rd_cond = rd & hit_cond;
        acc.rd_comp = rd & hit_comp;
        acc.wr_cond = wr & hit_cond;
        acc.wr_comp = wr & hit_comp;
    end

endmodule

// File: rtl/icr_snapshot.sv
module icr_snapshot
    import icr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap_en,
    input  logic  load_en,
    input  cond_t cond_i,
    input  cond_t wdata_i,
    output cond_t snap_o
);

    cond_t snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (load_en) begin
            snap_q <= wdata_i;
        end else if (cap_en) begin
            snap_q <= cond_i;
        end
    end

    assign snap_o = snap_q;

    p_capture_on_read_r3: assert property (@(posedge clk) disable iff (rst)
        (cap_en && !load_en) |=> (snap_q == $past(cond_i)));

    p_direct_load_r10: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (snap_q == $past(wdata_i)));

endmodule

// File: rtl/icr_cond_reg.sv
module icr_cond_reg
    import icr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  cond_t wdata_i,
    input  cond_t snap_i,
    input  cond_t event_i,
    output cond_t cond_o
);

    cond_t cond_q;
    cond_t cond_d;
    cond_t stale;
    logic  reject;

    always_comb begin
        stale  = stale_bits(cond_q, snap_i);
        reject = wr_en && (stale != '0);
    end

    for (genvar i = 0; i < int'(DATA_W); i++) begin : g_bit
        localparam bit IS_INHIBIT = (i == int'(INHIBIT_POS));
        always_comb begin
            cond_d[i] = bit_next(cond_q[i], stale[i], wr_en, wdata_i[i],
                                 IS_INHIBIT && reject, event_i[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
        end else begin
            cond_q <= cond_d;
        end
    end

    assign cond_o = cond_q;

    // matching bits take the written value (unless an event or a forced inhibit)
    p_match_takes_write_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (((cond_q ^ $past(wdata_i)) & ~$past(cond_q ^ snap_i) & ~$past(event_i)
                    & ~(($past(cond_q) != $past(snap_i)) ? INHIBIT_MASK : cond_t'(0))) == '0));

    p_stale_bits_hold_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (((cond_q ^ $past(cond_q)) & $past(cond_q ^ snap_i) & ~$past(event_i)
                    & ~INHIBIT_MASK) == '0));

    p_reject_sets_inhibit_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (cond_q != snap_i)) |=> cond_q[INHIBIT_POS]);

    p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (event_i != '0) |=> ((cond_q & $past(event_i)) == $past(event_i)));

    p_sticky_without_write_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((cond_q & $past(cond_q)) == $past(cond_q)));

endmodule

// File: rtl/icr_condwrite.sv
module icr_condwrite
    import icr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [DATA_W-1:0]    event_in,
    output logic                 irq
);

    bus_acc_t acc;
    cond_t    cond;
    cond_t    snap;

    icr_bus_decode #(
        .AW    (ADDR_W),
        .A_CND (COND_ADDR),
        .A_CMP (COMP_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .acc  (acc)
    );

    icr_snapshot u_snapshot (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (acc.rd_cond),
        .load_en (acc.wr_comp),
        .cond_i  (cond),
        .wdata_i (bus_wdata),
        .snap_o  (snap)
    );

    icr_cond_reg u_cond (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (acc.wr_cond),
        .wdata_i (bus_wdata),
        .snap_i  (snap),
        .event_i (event_in),
        .cond_o  (cond)
    );

    always_comb begin
        if (acc.rd_cond) begin
            bus_rdata = cond;
        end else if (acc.rd_comp) begin
            bus_rdata = snap;
        end else begin
            bus_rdata = '0;
        end
    end

    assign irq = |cond;

    p_comp_write_leaves_cond_r10: assert property (@(posedge clk) disable iff (rst)
        acc.wr_comp |=> (cond == ($past(cond) | $past(event_in))));

endmodule

// File: tb/icr_condwrite_tb.sv
`timescale 1ns/1ps
module icr_condwrite_tb;

    localparam logic [7:0] A_COND = 8'h19;
    localparam logic [7:0] A_COMP = 8'h1A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] event_in = '0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    logic [7:0] m_cond = '0;
    logic [7:0] m_snap = '0;

    always #2.5 clk = ~clk;

    icr_condwrite u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .event_in  (event_in),
        .irq       (irq)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_read(logic [7:0] a);
        if (a == A_COND) return m_cond;
        if (a == A_COMP) return m_snap;
        return 8'h00;
    endfunction

    // One bus cycle: drive after the edge, expect, then update the model at the next edge
    task automatic op(logic [7:0] a, logic rd, logic wr, logic [7:0] wd,
                      logic [7:0] ev, string req);
        logic [7:0] stale;
        logic [7:0] nc;
        logic [7:0] ns;
        #0.5;
        bus_addr  = a;
        bus_rd    = rd;
        bus_wr    = wr;
        bus_wdata = wd;
        event_in  = ev;
        if (rd) exp_q.push_back('{model_read(a), req});
        @(posedge clk);
        stale = m_cond ^ m_snap;
        nc = m_cond;
        ns = m_snap;
        if (rd && a == A_COND) ns = m_cond;
        if (wr && a == A_COMP) ns = wd;
        if (wr && a == A_COND) begin
            nc = (m_cond & stale) | (wd & ~stale);
            if (stale != 0) nc[3] = 1'b1;
        end
        nc = nc | ev;
        m_cond = nc;
        m_snap = ns;
    endtask

    task automatic rd_op(logic [7:0] a, string req);
        op(a, 1'b1, 1'b0, 8'h00, 8'h00, req);
    endtask

    task automatic wr_op(logic [7:0] a, logic [7:0] d, logic [7:0] ev, string req);
        op(a, 1'b0, 1'b1, d, ev, req);
    endtask

    task automatic ev_op(logic [7:0] ev);
        op(8'h00, 1'b0, 1'b0, 8'h00, ev, "R8");
    endtask

    // Monitor: scoreboard pop on every read, irq compare every cycle
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                check("R9 irq", {7'b0, irq}, {7'b0, (m_cond != 0)});
                if (bus_rd) begin
                    if (exp_q.size() == 0) begin
                        checks++;
                        errors++;
                        $display("FAIL scoreboard: unexpected read, actual %02h expected none", bus_rdata);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(e.req, bus_rdata, e.val);
                    end
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst = 1'b0;
        @(posedge clk);
        // R1: reset state
        rd_op(A_COND, "R1 cond");
        rd_op(A_COMP, "R1 snap");
        // R8: events set bits 0 and 5, and they stay set
        ev_op(8'h21);
        ev_op(8'h00);
        rd_op(A_COND, "R8 sticky set");
        // R3/R4: read, then write back clears
        wr_op(A_COND, 8'h00, 8'h00, "R4");
        rd_op(A_COND, "R4 cleared");
        rd_op(A_COMP, "R3 snapshot");
        // R5/R6: new event, write-back without a fresh read
        ev_op(8'h40);
        rd_op(A_COMP, "R3 comp read no capture");
        wr_op(A_COND, 8'h00, 8'h00, "R5");
        rd_op(A_COND, "R5 R6 held and inhibit");
        // R11: inhibit bit clears when it matches
        wr_op(A_COND, 8'h00, 8'h00, "R11");
        rd_op(A_COND, "R11 inhibit cleared");
        // R11: inhibit set by event after the snapshot is protected
        ev_op(8'h08);
        wr_op(A_COND, 8'h00, 8'h00, "R11");
        rd_op(A_COND, "R11 inhibit held");
        wr_op(A_COND, 8'h00, 8'h00, "R11");
        rd_op(A_COND, "R11 inhibit cleared again");
        // R10: direct snapshot load
        wr_op(A_COMP, 8'hFF, 8'h00, "R10");
        rd_op(A_COMP, "R10 snap loaded");
        wr_op(A_COND, 8'h00, 8'h00, "R10");
        rd_op(A_COMP, "R10 snap kept");
        rd_op(A_COND, "R10 R6 write refused");
        // R7: event in same cycle as clearing write
        wr_op(A_COND, 8'h00, 8'h80, "R7");
        rd_op(A_COND, "R7 event wins");
        // R4: matching bits take written ones
        wr_op(A_COND, 8'h84, 8'h00, "R4");
        rd_op(A_COND, "R4 set by write");
        // R2: unmapped address
        rd_op(8'h00, "R2 unmapped");
        rd_op(8'h1B, "R2 unmapped");
        // R8: every bit position maps to its event
        for (int i = 0; i < 8; i++) begin
            rd_op(A_COND, "R8 pre");
            wr_op(A_COND, 8'h00, 8'h00, "R8");
            ev_op(8'h01 << i);
            rd_op(A_COND, "R8 bit position");
        end
        #0.5;
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        event_in = 8'h00;
        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule